// File: doc/BRIEF.md
# SPI Master/Slave Port Controller with Mode-Fault Handling

This block is a byte-wide serial peripheral interface. It can act as the clock-driving master or as a slave that is clocked from outside. Software drives it through a small register port with three locations. A control register sets the operating mode. A status register reports transfer completion and mode faults. A data register is written to send a byte and read to collect the byte received. In master mode, a write to the data register starts an 8-bit exchange. SCK then toggles sixteen times, with each half period lasting a fixed number of system clocks. In slave mode, the block shifts on the SCK edges it receives while its select input is low.

Clock polarity and clock phase can be set to all four combinations. The bit order on the wire can be selected, and the data register always keeps its most significant bit in bit 7. If the port is a master with its select pin configured as an input and that pin is pulled low, another master is contending for the bus. The block then stops the transfer, releases its SCK and MOSI drivers and raises a mode-fault flag. Software recovers through a fixed read-then-write sequence. An open-drain option converts every port output, SPI and general purpose, to drive-low-only.

Top module: `spi_port_ctrl`

## Requirements
- R1: After reset, the control register (address 0), the status register (address 1) and all four pin output enables read as zero, and irq is low.
- R2: With enable (control bit 6) and master (control bit 4) set, a write to the data register (address 2) exchanges 8 bits with the attached slave. Afterwards the data register reads the slave's byte and status bit 7 (transfer complete) is set.
- R3: In master mode, sck_out rests at the clock-polarity value (control bit 3) between transfers and toggles exactly 16 times per transfer.
- R4: With clock phase (control bit 2) at 0, the first bit is on MOSI before the first SCK edge and is sampled on odd edges. With it at 1, bits are sampled on even edges. Both sides shift on the other edges.
- R5: With LSB-first (control bit 0) at 1, bit 0 goes on the wire first, otherwise bit 7 goes first. The data register holds the byte in its natural bit positions in both cases.
- R6: Transfer complete clears only after a status read that sees it set, followed by a data-register read or write. A data access alone leaves it set.
- R7: irq is high while interrupt enable (control bit 7) is 1 and either status bit 7 or status bit 6 is set.
- R8: A master with ss_dir at 0 that samples ss_in low sets mode fault (status bit 6). It stops the transfer without setting transfer complete, drops sck_oe and mosi_oe, and reads control bits 6 and 4 as zero.
- R9: Mode fault clears only after a status read that sees it set, followed by a control write. A control write alone leaves it set.
- R10: ss_oe is 1 only in master mode with SS output enable (control bit 1) and ss_dir both 1. ss_out is low while a transfer runs.
- R11: With wired-OR (control bit 5) at 1, open_drain is 1, and every output whose value is 1 has its output enable released.
- R12: In slave mode (control bit 4 at 0), miso_oe is 1 only while ss_in is low. The block then shifts its data-register byte out on MISO and collects MOSI on the received SCK edges, following R4 and R5.
- R13: Clearing enable during a master transfer aborts it without setting transfer complete, releases the pins, and returns SCK to idle once enable is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the flag-clear sequences) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq | output | 1 | Interrupt request |
| ss_dir | input | 1 | Direction bit of the SS pin, 1 = output |
| sck_in | input | 1 | SCK pin level (slave clock) |
| sck_out | output | 1 | SCK drive value |
| sck_oe | output | 1 | SCK driver enable |
| mosi_in | input | 1 | MOSI pin level (slave data in) |
| mosi_out | output | 1 | MOSI drive value |
| mosi_oe | output | 1 | MOSI driver enable |
| miso_in | input | 1 | MISO pin level (master data in) |
| miso_out | output | 1 | MISO drive value |
| miso_oe | output | 1 | MISO driver enable |
| ss_in | input | 1 | SS pin level |
| ss_out | output | 1 | SS drive value |
| ss_oe | output | 1 | SS driver enable |
| open_drain | output | 1 | Wired-OR indication for every port output |

## Verification
The assertions assume that sck_in, mosi_in and ss_in are synchronous to clk and that each level is held for at least two clocks. They also assume that ss_in is back high before the recovering control write, so that a fault is not raised again at once. The bench drives every pin and register strobe on the falling clock edge. It holds each SCK half period for four clocks in both directions and releases ss_in before the recovery write. The loopback slave model follows the same phase and bit-order rules at its own pins. A mismatch in any of the four clock modes therefore shows up as a wrong byte on one side or the other.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
// Package: register map, control-register layout and pin indices shared
// by the SPI port controller. Assumes an 8-bit register word.
package spi_port_pkg;
    localparam int WORD_W = 8;
    localparam int PIN_N  = 4;
    localparam int PIN_SCK  = 0;
    localparam int PIN_MOSI = 1;
    localparam int PIN_MISO = 2;
    localparam int PIN_SS   = 3;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic irq_en;
        logic enable;
        logic wired_or;
        logic master;
        logic cpol;
        logic cpha;
        logic ss_out_en;
        logic lsb_first;
    } ctrl_t;
endpackage

// File: rtl/spi_port_regs.sv
`timescale 1ns/1ps
// Register block: holds control, the two sticky flags and the receive buffer.
// Detects the mode fault and runs the read-then-access clear sequences.
// Assumes ss_in is synchronous to clk.
module spi_port_regs
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              xfer_done,
    input  logic              ss_in,
    input  logic              ss_dir,
    output ctrl_t             cfg,
    output logic              done_flag,
    output logic              fault_flag,
    output logic              data_load
);
    ctrl_t             ctrl_q;
    logic              done_q, fault_q, done_seen, fault_seen;
    logic [WORD_W-1:0] rx_buf;

    logic sel_ctrl, sel_stat, sel_data, fault_hit;
    assign sel_ctrl  = (addr == REG_CTRL);
    assign sel_stat  = (addr == REG_STAT);
    assign sel_data  = (addr == REG_DATA);
    assign fault_hit = ctrl_q.enable & ctrl_q.master & ~ss_dir & ~ss_in & ~fault_q;
    assign data_load = wr_en & sel_data;

    // Control register: software write, with enable and master cleared by a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_en && sel_ctrl) ctrl_q <= ctrl_t'(wdata);
            if (fault_hit) begin
                ctrl_q.enable <= 1'b0;
                ctrl_q.master <= 1'b0;
            end
        end
    end

    // Transfer-complete flag and its status-read arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            done_seen <= 1'b0;
        end else begin
            if (rd_en && sel_stat && done_q) done_seen <= 1'b1;
            else if (!done_q)                done_seen <= 1'b0;
            if (xfer_done)
                done_q <= 1'b1;
            else if (done_seen && sel_data && (rd_en || wr_en))
                done_q <= 1'b0;
        end
    end

    // Mode-fault flag and its status-read arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q    <= 1'b0;
            fault_seen <= 1'b0;
        end else begin
            if (rd_en && sel_stat && fault_q) fault_seen <= 1'b1;
            else if (!fault_q)                fault_seen <= 1'b0;
            if (fault_hit)
                fault_q <= 1'b1;
            else if (fault_seen && sel_ctrl && wr_en)
                fault_q <= 1'b0;
        end
    end

    // Receive buffer: captures the shifter contents when a transfer completes.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_buf <= '0;
        else if (xfer_done) rx_buf <= rx_data;
    end

    // Effective configuration: enable and master masked while a fault is pending.
    always_comb begin
        cfg        = ctrl_q;
        cfg.enable = ctrl_q.enable & ~fault_q;
        cfg.master = ctrl_q.master & ~fault_q;
    end

    assign done_flag  = done_q;
    assign fault_flag = fault_q;

    // Read multiplexer.
    always_comb begin
        unique case (addr)
            REG_CTRL: rdata = WORD_W'(cfg);
            REG_STAT: rdata = {done_q, fault_q, {(WORD_W-2){1'b0}}};
            REG_DATA: rdata = rx_buf;
            default:  rdata = '0;
        endcase
    end

    // R6: transfer complete stays set until a data access
    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !(sel_data && (rd_en || wr_en))) |=> done_q);
    // R9: mode fault stays set until a control write
    p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !(wr_en && sel_ctrl)) |=> fault_q);
    // R9: a fault only clears on a control write after a status read
    p_fault_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_q) |-> $past(wr_en && sel_ctrl && fault_seen));
endmodule

// File: rtl/spi_port_engine.sv
`timescale 1ns/1ps
// Shift engine shared by master and slave. The master generates SCK from a
// fixed half-period divider. The slave detects edges on sck_in while ss_in
// is low. Both count 2*DATA_W edges and sample or shift according to the
// clock phase. Assumes sck_in is synchronous to clk and held >= 2 clocks.
module spi_port_engine #(
    parameter int DATA_W   = 8,
    parameter int DIV_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              master,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              sck_in,
    input  logic              ss_in,
    input  logic              mosi_in,
    input  logic              miso_in,
    output logic              sck_q,
    output logic              tx_bit,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);
    localparam int EDGES = 2 * DATA_W;
    localparam int CNT_W = $clog2(EDGES);
    localparam int DIV_W = $clog2(DIV_HALF + 1);

    logic [DATA_W-1:0] tx_sh, rx_sh;
    logic [CNT_W-1:0]  edge_cnt;
    logic [DIV_W-1:0]  div_cnt;
    logic              sck_in_q;

    logic slave_act, m_tick, s_tick, tick, in_bit, samp, last, first;
    assign slave_act = en & ~master & ~ss_in;
    assign m_tick    = busy & master & (div_cnt == DIV_W'(DIV_HALF - 1));
    assign s_tick    = slave_act & (sck_in != sck_in_q);
    assign tick      = m_tick | s_tick;
    assign in_bit    = master ? miso_in : mosi_in;
    assign samp      = (edge_cnt[0] == cpha);
    assign last      = (edge_cnt == CNT_W'(EDGES - 1));
    assign first     = (edge_cnt == '0);

    // Edge detector history for the received slave clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_in_q <= 1'b0;
        else        sck_in_q <= sck_in;
    end

    // Transfer sequencer: divider, SCK toggling, edge counting, sample and shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; done <= 1'b0; sck_q <= 1'b0;
            edge_cnt <= '0; div_cnt <= '0; tx_sh <= '0; rx_sh <= '0;
        end else if (!en) begin
            busy <= 1'b0; done <= 1'b0; sck_q <= cpol;
            edge_cnt <= '0; div_cnt <= '0;
        end else begin
            done <= 1'b0;
            if (load && !busy && !slave_act) tx_sh <= load_data;
            if (master) begin
                if (!busy) begin
                    sck_q <= cpol; div_cnt <= '0; edge_cnt <= '0;
                    busy  <= load;
                end else begin
                    div_cnt <= m_tick ? '0 : div_cnt + 1'b1;
                    if (m_tick) sck_q <= ~sck_q;
                end
            end else begin
                sck_q <= cpol;
                busy  <= 1'b0;
                if (!slave_act) edge_cnt <= '0;
            end
            if (tick) begin
                if (samp)
                    rx_sh <= lsb_first ? {in_bit, rx_sh[DATA_W-1:1]}
                                       : {rx_sh[DATA_W-2:0], in_bit};
                else if (!first)
                    tx_sh <= lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
                edge_cnt <= last ? '0 : edge_cnt + 1'b1;
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign tx_bit  = lsb_first ? tx_sh[0] : tx_sh[DATA_W-1];
    assign rx_data = rx_sh;

    // R3: an idle master returns SCK to the polarity level
    p_idle_sck_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master && !busy && !load) |=> (sck_q == $past(cpol)));
    // R2: completion is reported only right after a counted edge
    p_done_after_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(tick) && edge_cnt == '0));
endmodule

// File: rtl/spi_port_pads.sv
`timescale 1ns/1ps
// Pad gating: applies wired-OR (drive-low-only) behaviour to every port
// output. Assumes a pull-up on the board provides the released high level.
module spi_port_pads #(
    parameter int N = 4
) (
    input  logic [N-1:0] out_val,
    input  logic [N-1:0] oe_raw,
    input  logic         wired_or,
    output logic [N-1:0] oe
);
    // One gate per pin: release the driver when open-drain and driving high.
    for (genvar i = 0; i < N; i++) begin : g_pin
        assign oe[i] = oe_raw[i] & ~(wired_or & out_val[i]);
    end
endmodule

// File: rtl/spi_port_ctrl.sv
`timescale 1ns/1ps
// Top: SPI port controller. Connects the register block, the shift engine
// and the pad gating, and forms the raw pin enables from the mode.
// Assumes all pin inputs are synchronous to clk.
module spi_port_ctrl
    import spi_port_pkg::*;
#(
    parameter int DIV_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              irq,
    input  logic              ss_dir,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              mosi_in,
    output logic              mosi_out,
    output logic              mosi_oe,
    input  logic              miso_in,
    output logic              miso_out,
    output logic              miso_oe,
    input  logic              ss_in,
    output logic              ss_out,
    output logic              ss_oe,
    output logic              open_drain
);
    ctrl_t             cfg;
    logic              done_flag, fault_flag, data_load;
    logic              xfer_done, busy, sck_q, tx_bit;
    logic [WORD_W-1:0] rx_data;
    logic [PIN_N-1:0]  pin_val, pin_oe_raw, pin_oe;

    spi_port_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_data(rx_data), .xfer_done(xfer_done),
        .ss_in(ss_in), .ss_dir(ss_dir), .cfg(cfg), .done_flag(done_flag),
        .fault_flag(fault_flag), .data_load(data_load)
    );

    spi_port_engine #(.DATA_W(WORD_W), .DIV_HALF(DIV_HALF)) u_engine (
        .clk(clk), .rst_n(rst_n), .en(cfg.enable), .master(cfg.master),
        .cpol(cfg.cpol), .cpha(cfg.cpha), .lsb_first(cfg.lsb_first),
        .load(data_load), .load_data(wdata), .sck_in(sck_in), .ss_in(ss_in),
        .mosi_in(mosi_in), .miso_in(miso_in), .sck_q(sck_q), .tx_bit(tx_bit),
        .busy(busy), .done(xfer_done), .rx_data(rx_data)
    );

    // Raw pin values and enables by mode, before open-drain gating.
    always_comb begin
        pin_val[PIN_SCK]     = sck_q;
        pin_val[PIN_MOSI]    = tx_bit;
        pin_val[PIN_MISO]    = tx_bit;
        pin_val[PIN_SS]      = ~busy;
        pin_oe_raw[PIN_SCK]  = cfg.enable & cfg.master;
        pin_oe_raw[PIN_MOSI] = cfg.enable & cfg.master;
        pin_oe_raw[PIN_MISO] = cfg.enable & ~cfg.master & ~ss_in;
        pin_oe_raw[PIN_SS]   = cfg.enable & cfg.master & cfg.ss_out_en & ss_dir;
    end

    spi_port_pads #(.N(PIN_N)) u_pads (
        .out_val(pin_val), .oe_raw(pin_oe_raw), .wired_or(cfg.wired_or), .oe(pin_oe)
    );

    assign sck_out    = pin_val[PIN_SCK];
    assign mosi_out   = pin_val[PIN_MOSI];
    assign miso_out   = pin_val[PIN_MISO];
    assign ss_out     = pin_val[PIN_SS];
    assign sck_oe     = pin_oe[PIN_SCK];
    assign mosi_oe    = pin_oe[PIN_MOSI];
    assign miso_oe    = pin_oe[PIN_MISO];
    assign ss_oe      = pin_oe[PIN_SS];
    assign open_drain = cfg.wired_or;
    assign irq        = cfg.irq_en & (done_flag | fault_flag);

    // R8: a pending fault keeps the master drivers released
    p_fault_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> (!sck_oe && !mosi_oe));
    // R10: SS is only driven by a master
    p_ss_master_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ss_oe |-> (cfg.master && ss_dir));
    // R12: MISO is only driven by a selected slave
    p_miso_slave_r12: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> (!ss_in && !cfg.master));
endmodule

// File: tb/spi_port_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: loops the master into a behavioural slave in all clock modes and
// bit orders, drives the block as a slave, and runs the fault, flag, irq,
// open-drain and disable sequences.
module spi_port_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic       irq, ss_dir = 1'b1, sck_in = 1'b0, mosi_in = 1'b0, ss_in = 1'b1;
    logic       sck_out, sck_oe, mosi_out, mosi_oe, miso_in, miso_out, miso_oe;
    logic       ss_out, ss_oe, open_drain;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    spi_port_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq), .ss_dir(ss_dir),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
        .ss_in(ss_in), .ss_out(ss_out), .ss_oe(ss_oe), .open_drain(open_drain)
    );

    // Pin lines with pull-ups.
    logic sck_line, mosi_line, ss_line;
    assign sck_line  = sck_oe  ? sck_out  : 1'b1;
    assign mosi_line = mosi_oe ? mosi_out : 1'b1;
    assign ss_line   = ss_oe   ? ss_out   : 1'b1;

    // Behavioural slave on the master's lines.
    logic       m_arm = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0, m_ss_low = 1'b0;
    int         m_edges = 0;
    logic [7:0] m_tx = '0, m_rx = '0;
    assign miso_in = m_lsb ? m_tx[0] : m_tx[7];

    always @(sck_line) begin
        if (m_arm) begin
            if ((m_edges % 2) == int'(m_cpha))
                m_rx = m_lsb ? {mosi_line, m_rx[7:1]} : {m_rx[6:0], mosi_line};
            else if (m_edges != 0)
                m_tx = m_lsb ? (m_tx >> 1) : (m_tx << 1);
            if (!ss_line) m_ss_low = 1'b1;
            m_edges++;
            if (m_edges == 16) m_arm = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Control word: {irq_en, enable, wired_or, master, cpol, cpha, ss_out_en, lsb_first}
    function automatic logic [7:0] cw(logic ie, logic en, logic wo, logic ms,
                                      logic cp, logic ch, logic so, logic lb);
        return {ie, en, wo, ms, cp, ch, so, lb};
    endfunction

    function automatic logic bit_at(logic [7:0] b, int j, logic lb);
        return lb ? b[j] : b[7-j];
    endfunction

    task automatic arm_slave(input logic [7:0] sb, input logic ch, input logic lb);
        m_tx = sb; m_rx = '0; m_cpha = ch; m_lsb = lb; m_edges = 0; m_ss_low = 1'b0;
        m_arm = 1'b1;
    endtask

    // Drives the DUT as a slave and collects its MISO bits.
    task automatic slave_run(input logic [7:0] mb, input logic cp, input logic ch,
                             input logic lb, output logic [7:0] got, output logic oe_seen);
        int sh = 0;
        got = '0;
        sck_in = cp; mosi_in = bit_at(mb, 0, lb);
        cyc(2);
        ss_in = 1'b0;
        cyc(4);
        oe_seen = miso_oe;
        for (int k = 0; k < 16; k++) begin
            sck_in = ~sck_in;
            if ((k % 2) == int'(ch))
                got = lb ? {miso_out, got[7:1]} : {got[6:0], miso_out};
            else if (k != 0) begin
                sh++;
                if (sh < 8) mosi_in = bit_at(mb, sh, lb);
            end
            cyc(4);
        end
        ss_in = 1'b1;
        cyc(3);
    endtask

    logic [7:0] rv, got, mb, sb;
    logic       oe_seen;

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1: reset state
        reg_rd(2'd0, rv); chk("R1 ctrl", rv, 0);
        reg_rd(2'd1, rv); chk("R1 status", rv, 0);
        chk("R1 oe", {sck_oe, mosi_oe, miso_oe, ss_oe, irq}, 0);

        // R2/R3/R4/R5/R6/R10: master loopback over all modes and bit orders
        for (int mode = 0; mode < 4; mode++) begin
            for (int lb = 0; lb < 2; lb++) begin
                logic cp, ch;
                cp = mode[1]; ch = mode[0];
                mb = 8'(8'h3C + mode * 37 + lb * 129);
                sb = 8'(8'hA5 ^ (mode * 19) ^ (lb * 15));
                reg_wr(2'd0, cw(0, 1, 0, 1, cp, ch, 1, lb[0]));
                cyc(3);
                chk("R3 idle sck", sck_out, cp);
                arm_slave(sb, ch, lb[0]);
                reg_wr(2'd2, mb);
                cyc(80);
                chk("R2/R4 slave got master byte", m_rx, mb);
                chk("R3 edge count", m_edges, 16);
                chk("R10 ss low during transfer", m_ss_low, 1);
                chk("R3 sck idle after", sck_out, cp);
                reg_rd(2'd2, rv);
                chk("R5 data reg holds slave byte", rv, sb);
                reg_rd(2'd1, rv);
                chk("R6 flag kept after bare data read", rv[7], 1);
                reg_rd(2'd2, rv);
                reg_rd(2'd1, rv);
                chk("R6 flag cleared by sequence", rv[7], 0);
            end
        end

        // R7: interrupt follows the flag and the enable
        reg_wr(2'd0, cw(1, 1, 0, 1, 0, 0, 1, 0));
        arm_slave(8'h81, 0, 0);
        reg_wr(2'd2, 8'h7E);
        cyc(80);
        chk("R7 irq with flag", irq, 1);
        reg_wr(2'd0, cw(0, 1, 0, 1, 0, 0, 1, 0));
        cyc(1);
        chk("R7 irq masked", irq, 0);
        reg_rd(2'd1, rv); reg_wr(2'd2, 8'h00);
        cyc(80);
        m_arm = 1'b0;
        reg_rd(2'd1, rv); reg_rd(2'd2, rv);

        // R10: SS output enable conditions
        reg_wr(2'd0, cw(0, 1, 0, 1, 0, 0, 0, 0));
        cyc(1);
        chk("R10 ss_oe off without enable bit", ss_oe, 0);
        reg_wr(2'd0, cw(0, 1, 0, 1, 0, 0, 1, 0));
        cyc(1);
        chk("R10 ss_oe on", {ss_oe, ss_out}, 2'b11);

        // R11: open-drain behaviour
        reg_wr(2'd0, cw(0, 1, 1, 1, 1, 0, 1, 0));
        cyc(3);
        chk("R11 high sck released", {open_drain, sck_oe, ss_oe}, 3'b100);
        reg_wr(2'd0, cw(0, 1, 1, 1, 0, 1, 1, 0));
        cyc(3);
        chk("R11 low sck driven", sck_oe, 1);
        arm_slave(8'h5B, 1, 0);
        reg_wr(2'd2, 8'hC6);
        cyc(80);
        chk("R11 open-drain transfer", m_rx, 8'hC6);
        reg_rd(2'd1, rv); reg_rd(2'd2, rv);
        chk("R11 open-drain receive", rv, 8'h5B);

        // R13: disabling mid-transfer aborts
        reg_wr(2'd0, cw(0, 1, 0, 1, 0, 0, 1, 0));
        arm_slave(8'h11, 0, 0);
        reg_wr(2'd2, 8'h22);
        cyc(20);
        reg_wr(2'd0, cw(0, 0, 0, 1, 1, 0, 1, 0));
        cyc(80);
        m_arm = 1'b0;
        chk("R13 pins released", {sck_oe, mosi_oe, ss_oe}, 0);
        reg_rd(2'd1, rv); chk("R13 no completion", rv[7], 0);
        reg_wr(2'd0, cw(0, 1, 0, 1, 1, 0, 1, 0));
        cyc(3);
        chk("R13 sck idle after re-enable", {sck_oe, sck_out}, 2'b11);

        // R8: mode fault during a transfer
        ss_dir = 1'b0;
        reg_wr(2'd0, cw(1, 1, 0, 1, 0, 0, 0, 0));
        arm_slave(8'h33, 0, 0);
        reg_wr(2'd2, 8'h44);
        cyc(20);
        ss_in = 1'b0;
        cyc(3);
        reg_rd(2'd1, rv); chk("R8 fault flag", rv[7:6], 2'b01);
        chk("R8 drivers released", {sck_oe, mosi_oe}, 0);
        chk("R7 irq on fault", irq, 1);
        reg_rd(2'd0, rv); chk("R8 enable/master read zero", {rv[6], rv[4]}, 0);
        cyc(80);
        m_arm = 1'b0;
        ss_in = 1'b1;
        cyc(2);
        reg_rd(2'd2, rv);
        reg_rd(2'd1, rv); chk("R8 transfer never completes", rv[7], 0);

        // R9: recovery sequence (status read already done above, so read again later)
        reg_rd(2'd0, rv);
        ss_dir = 1'b1;
        // Reset arming: a control write after the read above clears; test a bare write first.
        rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
        ss_dir = 1'b0;
        reg_wr(2'd0, cw(0, 1, 0, 1, 0, 0, 0, 0));
        ss_in = 1'b0; cyc(3); ss_in = 1'b1; cyc(2);
        reg_wr(2'd0, cw(0, 1, 0, 1, 0, 0, 0, 0));
        cyc(1);
        reg_rd(2'd0, rv); chk("R9 bare write keeps fault masking", {rv[6], rv[4]}, 0);
        reg_rd(2'd1, rv); chk("R9 fault still set", rv[6], 1);
        ss_dir = 1'b1;
        reg_wr(2'd0, cw(0, 1, 0, 1, 0, 0, 1, 0));
        cyc(1);
        reg_rd(2'd1, rv); chk("R9 fault cleared", rv[6], 0);
        reg_rd(2'd0, rv); chk("R9 ctrl restored", rv, cw(0, 1, 0, 1, 0, 0, 1, 0));

        // R12: slave mode, two modes
        reg_wr(2'd0, cw(0, 1, 0, 0, 0, 0, 0, 0));
        reg_wr(2'd2, 8'h96);
        cyc(2);
        chk("R12 miso released when deselected", miso_oe, 0);
        slave_run(8'h4D, 0, 0, 0, got, oe_seen);
        chk("R12 miso driven when selected", oe_seen, 1);
        chk("R12 slave sent byte", got, 8'h96);
        reg_rd(2'd1, rv); chk("R12 slave completion", rv[7], 1);
        reg_rd(2'd2, rv); chk("R12 slave received byte", rv, 8'h4D);
        sck_in = 1'b1;
        reg_wr(2'd0, cw(0, 1, 0, 0, 1, 1, 0, 1));
        reg_wr(2'd2, 8'h2B);
        slave_run(8'hE1, 1, 1, 1, got, oe_seen);
        chk("R12 slave lsb-first sent", got, 8'h2B);
        reg_rd(2'd1, rv); reg_rd(2'd2, rv);
        chk("R12 slave lsb-first received", rv, 8'hE1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule